// File: doc/BRIEF.md
# Queue-or-Nest Interrupt Phase Sequencer

This block takes interrupt requests from two kinds of source: instruction-caused faults (internal) and device requests (external). It steps every interrupt it accepts through a fixed order of phases. First it asks the pipeline to finish older instructions (drain). Next it asks the rollback logic to cancel younger state changes (undo). It then saves a frame holding the return PC and the cause on a small internal stack, and loads the handler address from a vector table indexed by the cause. It then waits while the handler runs. On the handler's return strobe it drives the saved PC back to the fetch unit together with a resume pulse.

A request that arrives while a handler runs is either nested, which means it starts its own phase walk at once, or queued until the handler returns. A mode input picks the policy. In simple mode every external request waits and any internal fault inside a handler is fatal. In nesting mode internal faults always nest, and an external source nests only when it outranks the external source being served. An identifier output shows which source is being handled.

Top module: `irq_phase_seq`

## Requirements
- R1: An internal request is acknowledged (`req_ack`) in the same cycle it is presented while idle, or while a handler runs in nesting mode with no return strobe. An external request is acknowledged and latched only in a cycle where `pipe_advance` is high and the sequencer is not halted. Otherwise it is left unacknowledged and the source must keep holding it.
- R2: The cycle after acceptance, `drain_req` is high and stays high until `drain_done` is sampled. Then `undo_req` is high until `undo_done` is sampled. Then follow one save cycle and one vector cycle.
- R3: In the vector cycle, `pc_load_valid` is high for exactly one cycle and `pc_load` equals `vec_addr`. The lookup index `vec_cause` is {internal flag, source index}, with the flag in the MSB.
- R4: `id_internal`/`id_src` show the interrupt most recently started. When a nested handler returns, they show the outer interrupt again.
- R5: A `ret_strobe` sampled while a handler runs causes, in the next cycle, a one-cycle `resume_pulse` with `pc_load_valid` high and `pc_load` equal to the PC that was given with that interrupt's request.
- R6: Queued external requests start only from idle, lowest source index first. An internal request presented in idle goes ahead of any queued external request.
- R7: In nesting mode, an internal request during a handler starts a new phase walk. Its return resumes into the outer handler, and the sequencer stays in handler state without returning to idle.
- R8: In nesting mode, a queued external request nests during an external handler only if its index is lower than the current source index. During an internal handler, external requests only queue.
- R9: In simple mode, an internal request during a handler raises `err` and halts. While halted, no request is acknowledged and no phase strobe or PC load appears until reset.
- R10: The save stack holds 4 frames. A fifth nested save raises `err` and halts, with no fifth vector load.
- R11: After reset, all strobes and `err` are low, and `id_internal`/`id_src` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| nest_mode | input | 1 | 1 = nesting mode, 0 = simple mode |
| req_valid | input | 1 | Request present; held until acknowledged |
| req_internal | input | 1 | 1 = instruction fault, 0 = device request |
| req_src | input | 2 | Source index or fault cause |
| req_pc | input | 32 | PC to save for this request |
| req_ack | output | 1 | Request taken at this clock edge |
| pipe_advance | input | 1 | Pipeline advances all stages this cycle |
| drain_req | output | 1 | Finish older instructions |
| drain_done | input | 1 | Drain complete |
| undo_req | output | 1 | Cancel younger state changes |
| undo_done | input | 1 | Undo complete |
| vec_cause | output | 3 | Vector table index {internal, source} |
| vec_addr | input | 32 | Handler address read from the table |
| pc_load_valid | output | 1 | Load `pc_load` into the fetch PC |
| pc_load | output | 32 | Handler address or return PC |
| ret_strobe | input | 1 | Handler finished |
| resume_pulse | output | 1 | Return to interrupted code |
| id_internal | output | 1 | Identifier: current interrupt is internal |
| id_src | output | 2 | Identifier: current source index |
| err | output | 1 | Fatal fault or stack overflow; halted |

## Verification
The acknowledge is combinational in the cycle the request is presented. `drain_req` follows one cycle after acceptance, and each later phase follows one cycle after the handshake that closes the previous phase. The vector load comes two cycles after `undo_done` is sampled, and the resume pulse comes one cycle after the return strobe. The bench drives inputs just after each rising edge and advances a behavioural model at that edge. It compares every output against the model at the falling edge, so each result is checked in the exact cycle it is due. Ordered logs of vector causes and return PCs are also compared against hand-written expectations for the queueing, nesting and overflow cases.

// File: rtl/irqseq_pkg.sv
package irqseq_pkg;
  typedef enum logic [2:0] {
    PH_IDLE, PH_DRAIN, PH_UNDO, PH_SAVE, PH_VECT, PH_RUN, PH_RESUME, PH_HALT
  } phase_t;
endpackage

// File: rtl/irqseq_pend_queue.sv
module irqseq_pend_queue #(
  parameter int NSRC  = 4,
  parameter int PC_W  = 32,
  localparam int SRC_W = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_en,
  input  logic [SRC_W-1:0] set_src,
  input  logic [PC_W-1:0]  set_pc,
  input  logic             clr_en,
  input  logic [SRC_W-1:0] clr_src,
  output logic             any,
  output logic [SRC_W-1:0] low_src,
  output logic [PC_W-1:0]  low_pc
);
  logic [NSRC-1:0] pend;
  logic [PC_W-1:0] ppc [NSRC];

  // Lowest set index wins; zero when nothing is pending.
  function automatic logic [SRC_W-1:0] lowest(input logic [NSRC-1:0] v);
    logic [SRC_W-1:0] r;
    r = '0;
    for (int i = NSRC - 1; i >= 0; i--)
      if (v[i]) r = SRC_W'(i);
    return r;
  endfunction

  for (genvar g = 0; g < NSRC; g++) begin : g_slot
    wire hit_set = set_en && (set_src == SRC_W'(g));
    wire hit_clr = clr_en && (clr_src == SRC_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pend[g] <= 1'b0;
        ppc[g]  <= '0;
      end else begin
        if (hit_set)      pend[g] <= 1'b1;
        else if (hit_clr) pend[g] <= 1'b0;
        if (hit_set)      ppc[g]  <= set_pc;
      end
    end
  end

  assign any     = |pend;
  assign low_src = lowest(pend);
  assign low_pc  = ppc[low_src];

  a_r6_set_sticks: assert property (@(posedge clk) disable iff (!rst_n)
    set_en |=> any);
endmodule

// File: rtl/irqseq_save_stack.sv
module irqseq_save_stack #(
  parameter int DEPTH = 4,
  parameter int PC_W  = 32,
  parameter int SRC_W = 2,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic             pop,
  input  logic [PC_W-1:0]  push_pc,
  input  logic             push_int,
  input  logic [SRC_W-1:0] push_src,
  output logic [PC_W-1:0]  top_pc,
  output logic             below_int,
  output logic [SRC_W-1:0] below_src,
  output logic             one_left,
  output logic             full
);
  logic [CNT_W-1:0] cnt;
  logic [PC_W-1:0]  f_pc  [DEPTH];
  logic             f_int [DEPTH];
  logic [SRC_W-1:0] f_src [DEPTH];

  wire [IDX_W-1:0] wr_idx  = IDX_W'(cnt);
  wire [IDX_W-1:0] top_idx = IDX_W'(cnt - CNT_W'(1));
  wire [IDX_W-1:0] blw_idx = IDX_W'(cnt - CNT_W'(2));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        f_pc[i]  <= '0;
        f_int[i] <= 1'b0;
        f_src[i] <= '0;
      end
    end else if (push) begin
      f_pc[wr_idx]  <= push_pc;
      f_int[wr_idx] <= push_int;
      f_src[wr_idx] <= push_src;
      cnt <= cnt + CNT_W'(1);
    end else if (pop) begin
      cnt <= cnt - CNT_W'(1);
    end
  end

  assign top_pc    = f_pc[top_idx];
  assign below_int = f_int[blw_idx];
  assign below_src = f_src[blw_idx];
  assign one_left  = (cnt == CNT_W'(1));
  assign full      = (cnt == CNT_W'(DEPTH));

  a_r10_push_has_room: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);
  a_r5_pop_has_frame: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> (cnt != '0));
  a_r5_no_push_with_pop: assert property (@(posedge clk) disable iff (!rst_n)
    !(push && pop));
endmodule

// File: rtl/irq_phase_seq.sv
module irq_phase_seq
  import irqseq_pkg::*;
#(
  parameter int NSRC  = 4,
  parameter int PC_W  = 32,
  parameter int DEPTH = 4,
  localparam int SRC_W   = (NSRC > 1) ? $clog2(NSRC) : 1,
  localparam int CAUSE_W = SRC_W + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               nest_mode,
  input  logic               req_valid,
  input  logic               req_internal,
  input  logic [SRC_W-1:0]   req_src,
  input  logic [PC_W-1:0]    req_pc,
  output logic               req_ack,
  input  logic               pipe_advance,
  output logic               drain_req,
  input  logic               drain_done,
  output logic               undo_req,
  input  logic               undo_done,
  output logic [CAUSE_W-1:0] vec_cause,
  input  logic [PC_W-1:0]    vec_addr,
  output logic               pc_load_valid,
  output logic [PC_W-1:0]    pc_load,
  input  logic               ret_strobe,
  output logic               resume_pulse,
  output logic               id_internal,
  output logic [SRC_W-1:0]   id_src,
  output logic               err
);
  phase_t ph, ph_n;
  logic             cur_int;
  logic [SRC_W-1:0] cur_src;
  logic [PC_W-1:0]  cur_pc;

  logic             q_any;
  logic [SRC_W-1:0] q_src;
  logic [PC_W-1:0]  q_pc;
  logic [PC_W-1:0]  s_top_pc;
  logic             s_below_int, s_one_left, s_full;
  logic [SRC_W-1:0] s_below_src;

  // Named decision wires, also used by the assertions.
  wire in_idle  = (ph == PH_IDLE);
  wire in_run   = (ph == PH_RUN);
  wire ext_take = req_valid && !req_internal && pipe_advance && (ph != PH_HALT);
  wire int_idle = in_idle && req_valid && req_internal;
  wire int_run  = in_run && !ret_strobe && req_valid && req_internal;
  wire int_take = int_idle || (int_run && nest_mode);
  wire int_fatal = int_run && !nest_mode;
  wire ext_outranks = nest_mode && !cur_int && q_any && (q_src < cur_src);
  wire q_launch = (in_idle && !int_idle && q_any) ||
                  (in_run && !ret_strobe && !int_run && ext_outranks);
  wire launch   = int_take || q_launch;
  wire do_push  = (ph == PH_SAVE) && !s_full;
  wire do_pop   = (ph == PH_RESUME);

  irqseq_pend_queue #(.NSRC(NSRC), .PC_W(PC_W)) i_queue (
    .clk(clk), .rst_n(rst_n),
    .set_en(ext_take), .set_src(req_src), .set_pc(req_pc),
    .clr_en(q_launch), .clr_src(q_src),
    .any(q_any), .low_src(q_src), .low_pc(q_pc)
  );

  irqseq_save_stack #(.DEPTH(DEPTH), .PC_W(PC_W), .SRC_W(SRC_W)) i_stack (
    .clk(clk), .rst_n(rst_n),
    .push(do_push), .pop(do_pop),
    .push_pc(cur_pc), .push_int(cur_int), .push_src(cur_src),
    .top_pc(s_top_pc), .below_int(s_below_int), .below_src(s_below_src),
    .one_left(s_one_left), .full(s_full)
  );

  always_comb begin
    ph_n = ph;
    unique case (ph)
      PH_IDLE:   if (launch) ph_n = PH_DRAIN;
      PH_DRAIN:  if (drain_done) ph_n = PH_UNDO;
      PH_UNDO:   if (undo_done) ph_n = PH_SAVE;
      PH_SAVE:   ph_n = s_full ? PH_HALT : PH_VECT;
      PH_VECT:   ph_n = PH_RUN;
      PH_RUN: begin
        if (ret_strobe)     ph_n = PH_RESUME;
        else if (int_fatal) ph_n = PH_HALT;
        else if (launch)    ph_n = PH_DRAIN;
      end
      PH_RESUME: ph_n = s_one_left ? PH_IDLE : PH_RUN;
      default:   ph_n = PH_HALT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph      <= PH_IDLE;
      cur_int <= 1'b0;
      cur_src <= '0;
      cur_pc  <= '0;
    end else begin
      ph <= ph_n;
      if (launch) begin
        cur_int <= int_take;
        cur_src <= int_take ? req_src : q_src;
        cur_pc  <= int_take ? req_pc : q_pc;
      end else if (do_pop && !s_one_left) begin
        cur_int <= s_below_int;
        cur_src <= s_below_src;
      end
    end
  end

  assign req_ack       = ext_take || int_take;
  assign drain_req     = (ph == PH_DRAIN);
  assign undo_req      = (ph == PH_UNDO);
  assign vec_cause     = {cur_int, cur_src};
  assign pc_load_valid = (ph == PH_VECT) || do_pop;
  assign pc_load       = (ph == PH_VECT) ? vec_addr : s_top_pc;
  assign resume_pulse  = do_pop;
  assign id_internal   = cur_int;
  assign id_src        = cur_src;
  assign err           = (ph == PH_HALT);

  a_r1_ext_needs_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ack && !req_internal) |-> pipe_advance);
  a_r2_undo_after_drain: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(undo_req) |-> $past(drain_req));
  a_r3_vector_single: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_load_valid && !resume_pulse) |=> !pc_load_valid);
  a_r5_resume_loads: assert property (@(posedge clk) disable iff (!rst_n)
    resume_pulse |-> pc_load_valid);
  a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);
  a_r9_halt_silent: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !(req_ack || drain_req || undo_req || pc_load_valid));
endmodule

// File: tb/test_irq_phase_seq.sv
module test_irq_phase_seq;
  localparam int P_IDLE = 0, P_DRAIN = 1, P_UNDO = 2, P_SAVE = 3,
                 P_VECT = 4, P_RUN = 5, P_RESUME = 6, P_HALT = 7;

  logic clk = 1'b0, rst_n = 1'b0;
  logic nest_mode = 1'b0, req_valid = 1'b0, req_internal = 1'b0;
  logic [1:0] req_src = '0;
  logic [31:0] req_pc = '0;
  logic pipe_advance = 1'b0, drain_done = 1'b0, undo_done = 1'b0, ret_strobe = 1'b0;
  logic req_ack, drain_req, undo_req, pc_load_valid, resume_pulse, id_internal, err;
  logic [2:0] vec_cause;
  logic [31:0] vec_addr, pc_load;
  logic [1:0] id_src;

  always #4 clk = ~clk;   // 125 MHz

  assign vec_addr = 32'h100 + 32'(vec_cause) * 8;

  irq_phase_seq i_irq_phase_seq (
    .clk(clk), .rst_n(rst_n), .nest_mode(nest_mode),
    .req_valid(req_valid), .req_internal(req_internal), .req_src(req_src),
    .req_pc(req_pc), .req_ack(req_ack), .pipe_advance(pipe_advance),
    .drain_req(drain_req), .drain_done(drain_done), .undo_req(undo_req),
    .undo_done(undo_done), .vec_cause(vec_cause), .vec_addr(vec_addr),
    .pc_load_valid(pc_load_valid), .pc_load(pc_load), .ret_strobe(ret_strobe),
    .resume_pulse(resume_pulse), .id_internal(id_internal), .id_src(id_src),
    .err(err)
  );

  int n_chk = 0, n_fail = 0, cyc = 0;
  int vec_cnt = 0, res_cnt = 0;
  int vec_log[$], res_log[$];

  task automatic chk(input string tag, input longint got, input longint exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h (cycle %0d)", tag, got, exp, cyc);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int m_ph = P_IDLE;
  bit m_int = 0;
  int m_src = 0;
  bit m_pend[4];
  int m_ppc[4];
  int st_pc[$];
  bit st_int[$];
  int st_src[$];

  function automatic int m_low();
    for (int i = 0; i < 4; i++) if (m_pend[i]) return i;
    return -1;
  endfunction

  task automatic m_start(input bit fi, input int s, input int pc);
    m_int = fi; m_src = s; st_pc.push_back(pc); st_int.push_back(fi);
    st_src.push_back(s);
    m_ph = P_DRAIN;
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ph = P_IDLE; m_int = 0; m_src = 0;
      foreach (m_pend[i]) begin m_pend[i] = 0; m_ppc[i] = 0; end
      st_pc.delete(); st_int.delete(); st_src.delete();
    end else begin
      bit ext_ok;
      int lo, saved;
      ext_ok = req_valid && !req_internal && pipe_advance && m_ph != P_HALT;
      lo = m_low();
      case (m_ph)
        P_IDLE:
          if (req_valid && req_internal) m_start(1, int'(req_src), int'(req_pc));
          else if (lo >= 0) begin m_pend[lo] = 0; m_start(0, lo, m_ppc[lo]); end
        P_DRAIN: if (drain_done) m_ph = P_UNDO;
        P_UNDO:  if (undo_done) m_ph = P_SAVE;
        P_SAVE:  m_ph = (st_pc.size() > 4) ? P_HALT : P_VECT;
        P_VECT:  m_ph = P_RUN;
        P_RUN:
          if (ret_strobe) m_ph = P_RESUME;
          else if (req_valid && req_internal) begin
            if (nest_mode) m_start(1, int'(req_src), int'(req_pc));
            else m_ph = P_HALT;
          end else if (nest_mode && !m_int && lo >= 0 && lo < m_src) begin
            m_pend[lo] = 0; m_start(0, lo, m_ppc[lo]);
          end
        P_RESUME: begin
          saved = st_pc.pop_back(); void'(st_int.pop_back()); void'(st_src.pop_back());
          if (st_pc.size() == 0) m_ph = P_IDLE;
          else begin m_ph = P_RUN; m_int = st_int[$]; m_src = st_src[$]; end
        end
        default: m_ph = P_HALT;
      endcase
      if (ext_ok) begin m_pend[req_src] = 1; m_ppc[req_src] = int'(req_pc); end
    end
  end
  // Frames are pushed by the model at start; SAVE overflow means a 5th entry.

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      bit e_ack, e_ld;
      int e_pc;
      e_ack = (req_valid && !req_internal && pipe_advance && m_ph != P_HALT) ||
              (req_valid && req_internal &&
               (m_ph == P_IDLE || (m_ph == P_RUN && !ret_strobe && nest_mode)));
      e_ld = (m_ph == P_VECT) || (m_ph == P_RESUME);
      e_pc = (m_ph == P_VECT) ? 32'h100 + ((int'(m_int) * 4 + m_src) * 8)
                              : ((st_pc.size() > 0) ? st_pc[$] : 0);
      chk("R1 req_ack", req_ack, e_ack);
      chk("R2 drain/undo", {drain_req, undo_req}, {m_ph == P_DRAIN, m_ph == P_UNDO});
      chk("R3 pc_load_valid", pc_load_valid, e_ld);
      if (e_ld) chk("R3/R5 pc_load", pc_load, e_pc);
      chk("R5 resume_pulse", resume_pulse, m_ph == P_RESUME);
      chk("R4 identifier", {id_internal, id_src, vec_cause}, {m_int, 2'(m_src), m_int, 2'(m_src)});
      chk("R9 err", err, m_ph == P_HALT);
      if (pc_load_valid && !resume_pulse) begin vec_cnt++; vec_log.push_back(int'(vec_cause)); end
      if (resume_pulse) begin res_cnt++; res_log.push_back(int'(pc_load)); end
    end
  end

  // Drain finishes on its second cycle, undo on its first.
  int dcnt = 0;
  always @(posedge clk) begin
    #1;
    if (drain_req) begin drain_done = (dcnt >= 1); dcnt++; end
    else begin drain_done = 0; dcnt = 0; end
    undo_done = undo_req;
  end

  // ---------------- stimulus helpers ----------------
  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic drive_req(input bit fi, input int s, input int pc, input bit adv,
                           input int maxc, output bit got);
    got = 0;
    @(posedge clk); #1;
    req_valid = 1; req_internal = fi; req_src = 2'(s); req_pc = 32'(pc); pipe_advance = adv;
    for (int k = 0; k < maxc && !got; k++) begin
      @(negedge clk); got = req_ack;
      @(posedge clk); #1;
    end
    req_valid = 0; pipe_advance = 0;
  endtask

  task automatic wait_vec(input int n);
    for (int k = 0; k < 200 && vec_cnt < n; k++) @(posedge clk);
    #1;
  endtask

  task automatic ret_after(input int n);
    wait_vec(n);
    tick(2);
    ret_strobe = 1; tick(1); ret_strobe = 0;
  endtask

  task automatic do_reset();
    @(posedge clk); #1; rst_n = 0; tick(2); rst_n = 1;
    vec_log.delete(); res_log.delete(); vec_cnt = 0; res_cnt = 0;
  endtask

  task automatic chk_logs(input string tag, input int ev[$], input int er[$]);
    chk({tag, " vector count"}, vec_log.size(), ev.size());
    foreach (ev[i]) if (i < vec_log.size()) chk({tag, " vector cause"}, vec_log[i], ev[i]);
    chk({tag, " resume count"}, res_log.size(), er.size());
    foreach (er[i]) if (i < res_log.size()) chk({tag, " resume pc"}, res_log[i], er[i]);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin : main
    bit g;
    tick(3);
    // R11: reset values while held in reset
    chk("R11 reset outputs", {req_ack, drain_req, undo_req, pc_load_valid, resume_pulse, err},
        6'b0);
    chk("R11 reset identifier", {id_internal, id_src}, 3'b0);
    rst_n = 1;

    // S1 simple mode: one internal fault, full phase walk (R1 R2 R3 R5)
    drive_req(1, 1, 'h40, 0, 5, g);
    chk("R1 internal ack in idle", g, 1);
    ret_after(1); tick(3);
    chk_logs("R5 single fault", '{5}, '{'h40});

    // S2 external needs advance; queued ones served lowest first (R1 R6)
    drive_req(0, 3, 'h80, 0, 4, g);
    chk("R1 no ack without advance", g, 0);
    drive_req(0, 3, 'h80, 1, 4, g);
    chk("R1 ack with advance", g, 1);
    wait_vec(2);
    drive_req(0, 2, 'h90, 1, 4, g);
    drive_req(0, 1, 'ha0, 1, 4, g);
    ret_after(2); ret_after(3); ret_after(4); tick(3);
    chk_logs("R6 queue order", '{5, 3, 1, 2}, '{'h40, 'h80, 'ha0, 'h90});

    // S3 nesting mode: internal inside external handler (R7 R4)
    do_reset(); nest_mode = 1;
    drive_req(0, 2, 'h200, 1, 4, g);
    wait_vec(1);
    drive_req(1, 0, 'h300, 0, 4, g);
    chk("R7 nested internal ack", g, 1);
    ret_after(2); tick(2);
    chk("R7 back in outer id", {id_internal, id_src}, {1'b0, 2'd2});
    ret_after(2); tick(3);
    chk_logs("R7 nest", '{2, 4}, '{'h300, 'h200});

    // S4 nesting mode: outranking external nests, lower one queues (R8)
    do_reset();
    drive_req(0, 2, 'h400, 1, 4, g);
    wait_vec(1);
    drive_req(0, 3, 'h500, 1, 4, g);
    drive_req(0, 0, 'h600, 1, 4, g);
    ret_after(2); ret_after(2); ret_after(3); tick(3);
    chk_logs("R8 priority nest", '{2, 0, 3}, '{'h600, 'h400, 'h500});

    // S5 nesting mode: fifth save overflows (R10)
    do_reset();
    drive_req(1, 0, 'h10, 0, 4, g);
    for (int k = 1; k <= 4; k++) begin
      wait_vec(k);
      drive_req(1, 1, 'h10 + k, 0, 4, g);
    end
    tick(8);
    chk("R10 overflow err", err, 1);
    chk("R10 vectors before overflow", vec_cnt, 4);

    // S6 simple mode: internal fault in a handler is fatal (R9)
    do_reset(); nest_mode = 0;
    drive_req(0, 1, 'h700, 1, 4, g);
    wait_vec(1);
    drive_req(1, 2, 'h710, 0, 3, g);
    chk("R9 fatal not acked", g, 0);
    chk("R9 err raised", err, 1);
    drive_req(0, 0, 'h720, 1, 3, g);
    chk("R9 halted ignores external", g, 0);
    tick(4);
    chk("R9 no vector while halted", vec_cnt, 1);
    do_reset();
    tick(2);
    chk("R11 err cleared by reset", err, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule